// File: doc/BRIEF.md
# I2C Target Register Access Engine

This block is an I2C target that gives a bus controller access to a bank of registers held in the surrounding core logic. It watches SCL and SDA through a faster system clock. When it sees its own 7-bit target address, it acknowledges it. In a write transaction, the first byte after the address loads a retained register pointer. Any further bytes form register values, most significant byte first. Each complete value is handed to the core as a one-cycle write strobe.

In a read transaction, the engine fetches the register the pointer selects through a one-cycle read strobe. It then shifts the value out, most significant byte first. The controller ends the read with a not-acknowledge.

The pointer byte carries a block flag. While that flag is set, every complete register transfer, read or write, advances the pointer. The advance stops at the highest address. The flag lasts until STOP. The pointer itself lasts across transactions, so the controller can read the same register again without sending a new pointer byte.

Top module: `i2c_reg_engine`

## Requirements
- R1: After reset the engine does not pull SDA low. An address byte whose upper seven bits equal TARGET_ADDR is acknowledged. On a mismatch the address byte is not acknowledged, and no byte up to the next START is acknowledged or acted on.
- R2: When the R/W bit (bit 0 of the address byte) is 0, the next byte is acknowledged and loads the pointer. Bits [6:0] of that byte give the register address and bit 7 gives the block flag.
- R3: A write transaction that stops right after the pointer byte produces no register write strobe.
- R4: Register bytes arrive most significant first. A single one-cycle reg_wr_en carrying the whole value appears only after the final byte of the register has been acknowledged. No strobe appears after the first byte.
- R5: Without the block flag, bytes that follow the first complete register in a write are acknowledged but cause no write.
- R6: A read transaction (R/W bit 1) returns the register selected by the pointer last stored by a write, most significant byte first. The pointer is kept across transactions, so a repeated read needs no new pointer byte.
- R7: A not-acknowledge from the controller after a read byte ends the read. The engine then keeps SDA released until the next START. A STOP also releases SDA.
- R8: With the block flag set, the pointer advances by one after each committed register write, so consecutive values land at consecutive addresses.
- R9: With the block flag set, each register fetch pulses reg_rd_en for one cycle. After each register whose bytes were all acknowledged, the next fetch is taken from the following address.
- R10: In block mode the pointer stops at 0x7F. Further reads and writes in the same transaction keep using 0x7F.
- R11: STOP clears the block flag. A later read with no new pointer byte then returns the same register for every pair of bytes.
- R12: The engine changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled I2C clock line |
| sda_i | input | 1 | Sampled I2C data line |
| sda_oe | output | 1 | 1 pulls SDA low (to an open-drain pad) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 7 | Register address of the write |
| reg_wr_data | output | 16 | Register value of the write |
| reg_rd_en | output | 1 | One-cycle register fetch strobe |
| reg_rd_addr | output | 7 | Register address of the fetch |
| reg_rd_data | input | 16 | Register value returned by the core in the fetch cycle |

## Verification
The hazardous overlap is a register commit or fetch that falls in the same cycle as the block-mode pointer advance. That cycle must use the old pointer and leave the new one for the next register. At address 0x7F the advance must instead hold its value. Block writes and block reads that start at 0x7E and run three registers past it provoke this. The result is judged from the core register model: 0x7E takes the first value, 0x7F takes the last value, and address 0 stays untouched. Read-back must return the 0x7F value twice. Randomised single-register writes and read-backs at random addresses cover the plain pointer path around these cases.

// File: rtl/i2c_reg_pkg.sv
// Shared types for the I2C register access engine.
package i2c_reg_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = 4;

    // Transaction phase of the target.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WRITE,
        PH_READ,
        PH_IGNORE
    } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into the system clock and derives bus events.
// Assumes the system clock is several times faster than SCL, so that every
// SCL level lasts for more than SYNC_STAGES + 1 system clocks.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_s;

    // Synchroniser chains and one-cycle history; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Event decode from synchronised levels.
    always_comb begin
        scl_s     = scl_pipe[SYNC_STAGES-1];
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/i2c_reg_pointer.sv
// Retained register pointer with block flag. The pointer byte format is
// address in the low ADDR_W bits and the block flag in bit 7. Incrementing
// stops at the highest address instead of wrapping.
module i2c_reg_pointer #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [7:0]        load_val,
    input  logic              inc,
    input  logic              blk_clr,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_succ,
    output logic              blk
);
    localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

    // Saturating successor of the current pointer.
    always_comb ptr_succ = (ptr == PTR_MAX) ? ptr : ptr + 1'b1;

    // Pointer and block flag update; load wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            blk <= 1'b0;
        end else begin
            if (load) begin
                ptr <= load_val[ADDR_W-1:0];
                blk <= load_val[7];
            end else if (inc) begin
                ptr <= ptr_succ;
            end
            if (blk_clr) blk <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_target_fsm.sv
// Byte-level I2C target sequencer. It counts bits per 9-bit frame, decides
// acknowledges, assembles register values and streams read data.
// Assumes events from i2c_line_sync, and that reg_rd_data is valid in the
// same cycle as rd_en.
module i2c_target_fsm
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h48,
    parameter int         ADDR_W      = 7,
    parameter int         REG_BYTES   = 2,
    localparam int        REG_W       = REG_BYTES * BYTE_W,
    localparam int        IDX_W       = (REG_BYTES > 2) ? $clog2(REG_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              blk,
    input  logic [REG_W-1:0]  rd_data,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic [7:0]        ptr_load_val,
    output logic              ptr_inc,
    output logic              rd_en,
    output logic              rd_succ,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data
);
    phase_t               state_q;
    logic [BIT_CNT_W-1:0] bitcnt_q;
    logic                 ack_phase_q;
    logic                 ack_drive_q;
    logic                 ack_ok_q;
    logic                 rw_q;
    logic                 first_q;
    logic                 done_q;
    logic [IDX_W-1:0]     idx_q;
    logic [7:0]           rx_q;
    logic [7:0]           tx_q;
    logic [REG_W-1:0]     hold_q;
    logic [REG_W-1:0]     acc_q;

    logic ack_end;
    logic last_idx;
    logic rd_first;
    logic rd_next;
    logic wr_commit;

    // Frame event decode and strobes to the pointer and the core.
    always_comb begin
        ack_end      = scl_fall & ack_phase_q & (bitcnt_q == BIT_CNT_W'(9));
        last_idx     = (idx_q == IDX_W'(REG_BYTES - 1));
        rd_first     = ack_end & (state_q == PH_ADDR) & ack_drive_q & rw_q;
        rd_next      = ack_end & (state_q == PH_READ) & ack_ok_q & last_idx;
        wr_commit    = ack_end & (state_q == PH_WRITE) & ~first_q & ~done_q & last_idx;
        rd_en        = rd_first | rd_next;
        rd_succ      = rd_next & blk;
        ptr_load     = ack_end & (state_q == PH_WRITE) & first_q;
        ptr_load_val = rx_q;
        ptr_inc      = (rd_next | wr_commit) & blk;
        sda_oe       = (ack_phase_q & ack_drive_q) |
                       ((state_q == PH_READ) & ~ack_phase_q & ~tx_q[7]);
    end

    // Protocol sequencing per bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= PH_IDLE;
            bitcnt_q    <= '0;
            ack_phase_q <= 1'b0;
            ack_drive_q <= 1'b0;
            ack_ok_q    <= 1'b0;
            rw_q        <= 1'b0;
            first_q     <= 1'b0;
            done_q      <= 1'b0;
            idx_q       <= '0;
            rx_q        <= '0;
            tx_q        <= 8'hFF;
            hold_q      <= '0;
            acc_q       <= '0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_evt) begin
                state_q     <= PH_ADDR;
                bitcnt_q    <= '0;
                ack_phase_q <= 1'b0;
                ack_drive_q <= 1'b0;
                first_q     <= 1'b1;
                done_q      <= 1'b0;
                idx_q       <= '0;
                tx_q        <= 8'hFF;
            end else if (stop_evt) begin
                state_q     <= PH_IDLE;
                ack_phase_q <= 1'b0;
                ack_drive_q <= 1'b0;
                tx_q        <= 8'hFF;
            end else if (scl_rise) begin
                if (bitcnt_q < BIT_CNT_W'(8)) rx_q <= {rx_q[6:0], sda_s};
                if (bitcnt_q == BIT_CNT_W'(8)) ack_ok_q <= ~sda_s;
                if (bitcnt_q < BIT_CNT_W'(9)) bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall) begin
                if (!ack_phase_q && bitcnt_q == BIT_CNT_W'(8)) begin
                    ack_phase_q <= 1'b1;
                    case (state_q)
                        PH_ADDR: begin
                            ack_drive_q <= (rx_q[7:1] == TARGET_ADDR);
                            rw_q        <= rx_q[0];
                        end
                        PH_WRITE: ack_drive_q <= 1'b1;
                        default:  ack_drive_q <= 1'b0;
                    endcase
                end else if (!ack_phase_q && bitcnt_q != '0 && state_q == PH_READ) begin
                    tx_q <= {tx_q[6:0], 1'b1};
                end else if (ack_end) begin
                    ack_phase_q <= 1'b0;
                    ack_drive_q <= 1'b0;
                    bitcnt_q    <= '0;
                    case (state_q)
                        PH_ADDR: begin
                            if (!ack_drive_q) begin
                                state_q <= PH_IGNORE;
                            end else if (rw_q) begin
                                state_q <= PH_READ;
                                hold_q  <= rd_data;
                                tx_q    <= rd_data[REG_W-1 -: 8];
                                idx_q   <= '0;
                            end else begin
                                state_q <= PH_WRITE;
                                idx_q   <= '0;
                            end
                        end
                        PH_WRITE: begin
                            if (first_q) begin
                                first_q <= 1'b0;
                            end else if (!done_q) begin
                                if (last_idx) begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= {acc_q[REG_W-9:0], rx_q};
                                    idx_q   <= '0;
                                    done_q  <= ~blk;
                                end else begin
                                    acc_q <= {acc_q[REG_W-9:0], rx_q};
                                    idx_q <= idx_q + 1'b1;
                                end
                            end
                        end
                        PH_READ: begin
                            if (!ack_ok_q) begin
                                state_q <= PH_IGNORE;
                                tx_q    <= 8'hFF;
                            end else if (last_idx) begin
                                hold_q <= rd_data;
                                tx_q   <= rd_data[REG_W-1 -: 8];
                                idx_q  <= '0;
                            end else begin
                                tx_q   <= hold_q[REG_W-9 -: 8];
                                hold_q <= hold_q << 8;
                                idx_q  <= idx_q + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/i2c_reg_engine.sv
// Top of the I2C target register access engine. It wires line
// synchronisation, the retained pointer and the byte sequencer, and selects
// the fetch address for block reads. Assumes an open-drain pad outside:
// sda_oe high pulls SDA low.
module i2c_reg_engine #(
    parameter logic [6:0] TARGET_ADDR = 7'h48,
    parameter int         ADDR_W      = 7,
    parameter int         REG_BYTES   = 2,
    parameter int         SYNC_STAGES = 2,
    localparam int        REG_W       = REG_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [REG_W-1:0]  reg_wr_data,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [REG_W-1:0]  reg_rd_data
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              ptr_load;
    logic [7:0]        ptr_load_val;
    logic              ptr_inc;
    logic              rd_succ;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_succ;
    logic              blk_q;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2c_reg_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_load_val),
        .inc(ptr_inc), .blk_clr(stop_evt), .ptr(ptr_q), .ptr_succ(ptr_succ),
        .blk(blk_q)
    );

    i2c_target_fsm #(
        .TARGET_ADDR(TARGET_ADDR), .ADDR_W(ADDR_W), .REG_BYTES(REG_BYTES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .ptr(ptr_q), .blk(blk_q), .rd_data(reg_rd_data), .sda_oe(sda_oe),
        .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc),
        .rd_en(reg_rd_en), .rd_succ(rd_succ), .wr_en(reg_wr_en),
        .wr_addr(reg_wr_addr), .wr_data(reg_wr_data)
    );

    // Block reads fetch the next register while the pointer advances.
    always_comb reg_rd_addr = rd_succ ? ptr_succ : ptr_q;
endmodule

// File: rtl/i2c_reg_engine_chk.sv
// Assertion checker for i2c_reg_engine, attached by bind.
module i2c_reg_engine_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic              stop_evt,
    input logic              ptr_load,
    input logic [ADDR_W-1:0] ptr_q
);
    localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

    // R4: a commit is a single-cycle strobe
    a_r4_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R9: a fetch is a single-cycle strobe
    a_r9_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    // R7: STOP leaves SDA released
    a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R12: SDA drive moves only while SCL is low
    a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R10: the pointer holds at the top address unless reloaded
    a_r10_ptr_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ptr_q) == PTR_MAX && !$past(ptr_load)) |-> ptr_q == PTR_MAX);
endmodule

bind i2c_reg_engine i2c_reg_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .stop_evt(stop_evt),
    .ptr_load(ptr_load), .ptr_q(ptr_q)
);

// File: tb/i2c_reg_engine_test.sv
// Bench: bit-banged I2C controller, core register model, directed corner
// cases and seeded random single-register traffic.
module i2c_reg_engine_test;
    localparam logic [6:0] TADDR = 7'h48;
    localparam int         Q     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_scl = 1'b1;
    logic        ctl_sda = 1'b1;
    logic        sda_i;
    logic        sda_oe;
    logic        reg_wr_en;
    logic [6:0]  reg_wr_addr;
    logic [15:0] reg_wr_data;
    logic        reg_rd_en;
    logic [6:0]  reg_rd_addr;
    logic [15:0] reg_rd_data;

    logic [15:0] mem [0:127];
    logic [15:0] exp_mem [0:127];
    int          wr_cnt = 0;
    int          checks = 0;
    int          fails = 0;
    int          r12_viol = 0;
    logic        mon_on = 1'b0;
    logic        oe_prev = 1'b0;
    logic        finished = 1'b0;

    always #2 clk = ~clk;

    assign sda_i       = ctl_sda & ~sda_oe;
    assign reg_rd_data = mem[reg_rd_addr];

    i2c_reg_engine uut (
        .clk(clk), .rst_n(rst_n), .scl_i(ctl_scl), .sda_i(sda_i),
        .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    // Core register model.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= 16'h0000;
        end else if (reg_wr_en) begin
            mem[reg_wr_addr] <= reg_wr_data;
            wr_cnt = wr_cnt + 1;
        end
    end

    // R12 monitor: SDA drive must not move while SCL is high.
    always @(posedge clk) begin
        if (mon_on && sda_oe !== oe_prev && ctl_scl) r12_viol = r12_viol + 1;
        oe_prev = sda_oe;
    end

    function automatic logic [15:0] exp_word(input logic [6:0] a);
        return exp_mem[a];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        ctl_sda = 1'b1; hq(); ctl_scl = 1'b1; hq();
        ctl_sda = 1'b0; hq(); ctl_scl = 1'b0; hq();
    endtask

    task automatic i2c_stop();
        ctl_sda = 1'b0; hq(); ctl_scl = 1'b1; hq(); ctl_sda = 1'b1; hq();
    endtask

    task automatic send_bit(input logic b);
        ctl_sda = b; hq(); ctl_scl = 1'b1; hq(); hq(); ctl_scl = 1'b0; hq();
    endtask

    task automatic recv_bit(output logic b);
        ctl_sda = 1'b1; hq(); ctl_scl = 1'b1; hq(); b = sda_i; hq();
        ctl_scl = 1'b0; hq();
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic bt;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(bt);
        ack = ~bt;
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic give_ack);
        logic bt;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(bt);
            v[i] = bt;
        end
        send_bit(~give_ack);
    endtask

    // Plain single-register write; expected model updated.
    task automatic write_reg(input string req, input logic [6:0] a, input logic [15:0] d);
        logic ack;
        logic all_ack;
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack); all_ack = ack;
        wr_byte({1'b0, a}, ack);     all_ack &= ack;
        wr_byte(d[15:8], ack);       all_ack &= ack;
        wr_byte(d[7:0], ack);        all_ack &= ack;
        i2c_stop();
        exp_mem[a] = d;
        chk(req, {31'd0, all_ack}, 32'd1);
    endtask

    // Pointer write, repeated START, read one register with NACK.
    task automatic read_reg(input string req, input logic [6:0] a, input logic blkf,
                            output logic [15:0] d);
        logic ack;
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack);
        wr_byte({blkf, a}, ack);
        i2c_start();
        wr_byte({TADDR, 1'b1}, ack);
        chk(req, {31'd0, ack}, 32'd1);
        rd_byte(d[15:8], 1'b1);
        rd_byte(d[7:0], 1'b0);
        i2c_stop();
    endtask

    initial begin
        logic        ack;
        logic [7:0]  b;
        logic [15:0] w;
        int          base;
        int unsigned seed;

        seed = $urandom(32'd2024);
        for (int i = 0; i < 128; i++) exp_mem[i] = 16'h0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        mon_on = 1'b1;

        // R1: reset state
        chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
        chk("R1 reset wr_en", {31'd0, reg_wr_en}, 32'd0);

        // R1: mismatched address and the bytes after it
        i2c_start();
        wr_byte({7'h23, 1'b0}, ack);
        chk("R1 mismatch addr ack", {31'd0, ack}, 32'd0);
        wr_byte(8'h05, ack);
        chk("R1 ignored ptr ack", {31'd0, ack}, 32'd0);
        wr_byte(8'h11, ack);
        wr_byte(8'h22, ack);
        chk("R1 ignored data ack", {31'd0, ack}, 32'd0);
        i2c_stop();
        chk("R1 no write after mismatch", wr_cnt, 0);

        // R2 / R4: single register write, commit only after last byte
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack);
        chk("R1 match addr ack", {31'd0, ack}, 32'd1);
        wr_byte(8'h05, ack);
        chk("R2 ptr byte ack", {31'd0, ack}, 32'd1);
        wr_byte(8'hBE, ack);
        repeat (4) @(negedge clk);
        chk("R4 no commit after first byte", wr_cnt, 0);
        wr_byte(8'hEF, ack);
        repeat (4) @(negedge clk);
        chk("R4 one commit after last byte", wr_cnt, 1);
        i2c_stop();
        exp_mem[5] = 16'hBEEF;
        chk("R4 register value", mem[5], exp_word(7'h05));

        // R3: pointer-only write to 0x40
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack);
        wr_byte(8'h40, ack);
        i2c_stop();
        chk("R3 pointer-only no strobe", wr_cnt, 1);
        chk("R3 reg 0x40 untouched", mem[7'h40], 16'h0000);

        // R6: read via repositioned pointer, then repeated read without pointer
        read_reg("R6 read addr ack", 7'h05, 1'b0, w);
        chk("R6 read value", w, exp_word(7'h05));
        i2c_start();
        wr_byte({TADDR, 1'b1}, ack);
        rd_byte(w[15:8], 1'b1);
        rd_byte(w[7:0], 1'b0);
        i2c_stop();
        chk("R6 retained pointer read", w, exp_word(7'h05));

        // R5: extra bytes without block flag
        base = wr_cnt;
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack);
        wr_byte(8'h10, ack);
        wr_byte(8'h12, ack);
        wr_byte(8'h34, ack);
        wr_byte(8'h56, ack);
        chk("R5 extra byte ack", {31'd0, ack}, 32'd1);
        wr_byte(8'h78, ack);
        chk("R5 extra byte ack 2", {31'd0, ack}, 32'd1);
        i2c_stop();
        exp_mem[7'h10] = 16'h1234;
        chk("R5 one commit", wr_cnt - base, 1);
        chk("R5 reg 0x10", mem[7'h10], exp_word(7'h10));
        chk("R5 reg 0x11 untouched", mem[7'h11], exp_word(7'h11));

        // R8: block write of three registers from 0x20
        base = wr_cnt;
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack);
        wr_byte(8'hA0, ack);
        for (int k = 1; k <= 3; k++) begin
            wr_byte(8'hA0, ack);
            wr_byte(8'(k), ack);
            exp_mem[7'h1F + k] = {8'hA0, 8'(k)};
        end
        i2c_stop();
        chk("R8 three commits", wr_cnt - base, 3);
        for (int k = 0; k < 3; k++)
            chk("R8 block reg", mem[7'h20 + k], exp_word(7'(7'h20 + k)));

        // R9: block read of three registers from 0x20
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack);
        wr_byte(8'hA0, ack);
        i2c_start();
        wr_byte({TADDR, 1'b1}, ack);
        for (int k = 0; k < 3; k++) begin
            rd_byte(w[15:8], 1'b1);
            rd_byte(w[7:0], k != 2);
            chk("R9 block read", w, exp_word(7'(7'h20 + k)));
        end
        i2c_stop();

        // R11: block flag gone after STOP; pointer left at 0x22
        i2c_start();
        wr_byte({TADDR, 1'b1}, ack);
        for (int k = 0; k < 2; k++) begin
            rd_byte(w[15:8], 1'b1);
            rd_byte(w[7:0], k != 1);
            chk("R11 same register repeats", w, exp_word(7'h22));
        end
        i2c_stop();

        // R10: block write crossing 0x7E..0x7F
        base = wr_cnt;
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack);
        wr_byte(8'hFE, ack);
        wr_byte(8'h7E, ack); wr_byte(8'h7E, ack);
        wr_byte(8'h7F, ack); wr_byte(8'h01, ack);
        wr_byte(8'h7F, ack); wr_byte(8'h02, ack);
        i2c_stop();
        exp_mem[7'h7E] = 16'h7E7E;
        exp_mem[7'h7F] = 16'h7F02;
        chk("R10 three commits", wr_cnt - base, 3);
        chk("R10 reg 0x7E", mem[7'h7E], exp_word(7'h7E));
        chk("R10 reg 0x7F holds last", mem[7'h7F], exp_word(7'h7F));
        chk("R10 no wrap to 0x00", mem[7'h00], exp_word(7'h00));

        // R10: block read crossing 0x7F
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack);
        wr_byte(8'hFE, ack);
        i2c_start();
        wr_byte({TADDR, 1'b1}, ack);
        for (int k = 0; k < 3; k++) begin
            rd_byte(w[15:8], 1'b1);
            rd_byte(w[7:0], k != 2);
            chk("R10 saturated read", w, exp_word(k == 0 ? 7'h7E : 7'h7F));
        end
        i2c_stop();

        // R7: after NACK no further data is driven
        i2c_start();
        wr_byte({TADDR, 1'b0}, ack);
        wr_byte(8'h05, ack);
        i2c_start();
        wr_byte({TADDR, 1'b1}, ack);
        rd_byte(w[15:8], 1'b1);
        rd_byte(w[7:0], 1'b0);
        chk("R7 data before NACK", w, exp_word(7'h05));
        rd_byte(b, 1'b0);
        chk("R7 released after NACK", b, 8'hFF);
        chk("R7 sda_oe low after NACK", {31'd0, sda_oe}, 32'd0);
        i2c_stop();

        // R6 / R4: seeded random single-register writes and read-backs
        for (int n = 0; n < 20; n++) begin
            logic [6:0]  ra;
            logic [15:0] rd;
            ra = 7'($urandom_range(0, 127));
            rd = 16'($urandom);
            write_reg("R4 random write acks", ra, rd);
            read_reg("R6 random read ack", ra, 1'($urandom_range(0, 1)), w);
            chk("R6 random read-back", w, exp_word(ra));
        end

        chk("R12 SDA change while SCL high", r12_viol, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule